// File: doc/BRIEF.md
# Page Access Rights and Protection-Key Checker

This block receives the outcome of a page-table walk and decides what the requesting access may do with the page. From the walk it takes the combined user, writable and no-execute attributes, the 4-bit protection key of the leaf entry, and a flag saying that the walk met a reserved bit. From the requester it takes the privilege (user or supervisor), the access kind (load, store or instruction fetch), and the mode enables: write-protect, supervisor-execute prevention (SMEP), supervisor-access prevention for this access index (SMAP), no-execute enable, and the user-key and supervisor-key enables. Two 32-bit key-rights registers complete the inputs: one for user pages and one for supervisor pages.

A request is taken on a cycle where `req_valid` is high. On the next cycle `done` pulses and the result appears: a read/write/execute rights vector when the access is allowed, or a fault flag with a page-fault error code. The result stays on the outputs until the next request. Walking the tables and updating accessed or dirty bits are done elsewhere.

Top module: `pkey_perm_check`

## Requirements
- R1: A request sampled with `req_valid` high gives `done` high on the next cycle only, with `fault`, `perm` and `err_code` for that request held until the next request. After reset `done`, `fault`, `perm` and `err_code` are all zero.
- R2: A user-privilege access to a page whose user bit is clear faults with error code present (bit 0), plus the side flags of R10. This check comes after R9 and before any key or rights check.
- R3: Read rights (perm bit 0) are granted unless SMAP is active and the page is a user page.
- R4: Write rights (perm bit 1) are granted only together with read rights, and only if the page is writable or the access is supervisor with write-protect off.
- R5: Execute rights (perm bit 2) are granted when the page's no-execute bit is clear and at least one of these holds: the access is user-privilege, SMEP is off, or the page is a supervisor page.
- R6: A user page takes key rights from the user register when user keys are enabled. A supervisor page takes them from the supervisor register when supervisor keys are enabled. Otherwise the rights are treated as zero and keys have no effect.
- R7: For key k, rights bit 2k disables access: it removes read and write. Bit 2k+1 disables write: it removes write only when the access is user-privilege or write-protect is on. Keys never remove execute.
- R8: If the key rights deny the requested access kind, the access faults with error code key (bit 5) plus present (bit 0) and the R10 flags. An instruction fetch never takes this fault.
- R9: If the walk flagged a reserved bit, the access faults with error code reserved (bit 3) plus the R10 flags. This fault has the highest priority.
- R10: Every fault code adds user (bit 2) for user-privilege accesses, write (bit 1) for stores, and fetch (bit 4) for fetches only when no-execute enable or SMEP is on. Access encoding: 0 load, 1 store, 2 fetch.
- R11: When the requested access kind is missing from the base rights merged with the key rights, the access faults with error code present (bit 0) plus the R10 flags.
- R12: On a fault `perm` is zero. Without a fault `err_code` is zero and `perm` holds the merged rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| rsvd_hit | input | 1 | Walk found a reserved bit set |
| page_user | input | 1 | Combined user bit of the page |
| page_writable | input | 1 | Combined writable bit |
| page_noexec | input | 1 | Combined no-execute bit |
| page_key | input | 4 | Protection key of the leaf entry |
| priv_user | input | 1 | Access is user-privilege |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch |
| wp_en | input | 1 | Write-protect enable |
| smep_en | input | 1 | Supervisor-execute prevention enable |
| smap_act | input | 1 | Supervisor-access prevention active for this access index |
| nxe_en | input | 1 | No-execute enable |
| ukey_en | input | 1 | User-page keys enable |
| skey_en | input | 1 | Supervisor-page keys enable |
| ukey_rights | input | 32 | Key rights for user pages |
| skey_rights | input | 32 | Key rights for supervisor pages |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Access faults |
| perm | output | 3 | Granted rights: bit 0 read, 1 write, 2 execute |
| err_code | output | 6 | Page-fault error code |

## Verification
Two checks can hit the same request: a key denial and a base-rights denial. One example is a user-privilege load on a page whose key has access-disable set while SMAP also refuses the read. Another is a store where the key's write-disable and a read-only page both block the write. Directed requests set up these overlaps and also the overlap of a reserved-bit flag with a user/supervisor mismatch. The bench judges each one by whether the key flag appears in the code, and by whether the code matches the fixed priority of reserved, then privilege mismatch, then key, then plain rights.

// File: rtl/pkc_pkg.sv
// Shared encodings for the page access-rights checker.
// Assumes a 3-bit rights vector and a 6-bit fault code.
package pkc_pkg;
    localparam int ERR_W = 6;
    localparam int PERM_W = 3;

    // Rights vector bit positions
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

    // Fault code bit positions
    localparam int EC_PRESENT = 0;
    localparam int EC_WRITE   = 1;
    localparam int EC_USER    = 2;
    localparam int EC_RSVD    = 3;
    localparam int EC_FETCH   = 4;
    localparam int EC_KEY     = 5;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;
endpackage

// File: rtl/pkc_base_rights.sv
// Page rights before keys: read under SMAP, write under write-protect,
// execute under SMEP. Purely combinational.
module pkc_base_rights
    import pkc_pkg::*;
(
    input  logic              page_user,
    input  logic              page_writable,
    input  logic              page_noexec,
    input  logic              priv_user,
    input  logic              wp_en,
    input  logic              smep_en,
    input  logic              smap_act,
    output logic [PERM_W-1:0] base
);
    logic rd_ok;

    // Derive the three base rights from page bits and mode enables
    always_comb begin
        rd_ok         = !(smap_act && page_user);
        base          = '0;
        base[PERM_RD] = rd_ok;
        base[PERM_WR] = rd_ok && (page_writable || (!priv_user && !wp_en));
        base[PERM_EX] = !page_noexec && (priv_user || !smep_en || !page_user);
    end
endmodule

// File: rtl/pkc_key_rights.sv
// Selects the key-rights register by page type and turns the key's
// access-disable / write-disable pair into a rights mask.
// Assumes two rights bits per key, laid out by key number.
module pkc_key_rights
    import pkc_pkg::*;
#(
    parameter int KEY_W = 4,
    localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
    input  logic                page_user,
    input  logic [KEY_W-1:0]    page_key,
    input  logic                priv_user,
    input  logic                wp_en,
    input  logic                ukey_en,
    input  logic                skey_en,
    input  logic [RIGHTS_W-1:0] ukey_rights,
    input  logic [RIGHTS_W-1:0] skey_rights,
    output logic [PERM_W-1:0]   kmask
);
    logic [RIGHTS_W-1:0] sel;
    logic                acc_dis;
    logic                wr_dis;

    // Pick the register that governs this page, or zero when disabled
    always_comb begin
        if (page_user) sel = ukey_en ? ukey_rights : '0;
        else           sel = skey_en ? skey_rights : '0;
    end

    // Extract the key's pair and build the mask
    always_comb begin
        acc_dis        = sel[{page_key, 1'b0}];
        wr_dis         = sel[{page_key, 1'b1}];
        kmask          = '0;
        kmask[PERM_RD] = !acc_dis;
        kmask[PERM_WR] = !acc_dis && !(wr_dis && (priv_user || wp_en));
        kmask[PERM_EX] = 1'b1;
    end
endmodule

// File: rtl/pkc_fault_code.sv
// Resolves the fault class by fixed priority and builds the error code
// and final rights. Combinational.
module pkc_fault_code
    import pkc_pkg::*;
(
    input  logic              rsvd_hit,
    input  logic              page_user,
    input  logic              priv_user,
    input  logic [1:0]        acc_type,
    input  logic              nxe_en,
    input  logic              smep_en,
    input  logic [PERM_W-1:0] base,
    input  logic [PERM_W-1:0] kmask,
    output logic              fault,
    output logic [ERR_W-1:0]  err,
    output logic [PERM_W-1:0] perm
);
    logic [PERM_W-1:0] want;
    logic [PERM_W-1:0] merged;
    logic [ERR_W-1:0]  side;
    logic [ERR_W-1:0]  cls;

    // One-hot of the requested access kind (code 3 acts as load)
    always_comb begin
        want = '0;
        case (acc_type)
            ACC_STORE: want[PERM_WR] = 1'b1;
            ACC_FETCH: want[PERM_EX] = 1'b1;
            default:   want[PERM_RD] = 1'b1;
        endcase
    end

    // Flags added to every fault code
    always_comb begin
        side           = '0;
        side[EC_USER]  = priv_user;
        side[EC_WRITE] = (acc_type == ACC_STORE);
        side[EC_FETCH] = (acc_type == ACC_FETCH) && (nxe_en || smep_en);
    end

    // Priority: reserved, privilege mismatch, key denial, rights denial
    always_comb begin
        merged = base & kmask;
        cls    = '0;
        fault  = 1'b1;
        if (rsvd_hit) begin
            cls[EC_RSVD] = 1'b1;
        end else if (priv_user && !page_user) begin
            cls[EC_PRESENT] = 1'b1;
        end else if ((kmask & want) == '0) begin
            cls[EC_KEY]     = 1'b1;
            cls[EC_PRESENT] = 1'b1;
        end else if ((merged & want) == '0) begin
            cls[EC_PRESENT] = 1'b1;
        end else begin
            fault = 1'b0;
        end
        err  = fault ? (cls | side) : '0;
        perm = fault ? '0 : merged;
    end
endmodule

// File: rtl/pkey_perm_check.sv
// Top of the access-rights checker. Samples a request on req_valid and
// presents the registered verdict one cycle later with a done pulse.
// Assumes the walk has already merged user/writable/no-execute across levels.
module pkey_perm_check
    import pkc_pkg::*;
#(
    parameter int KEY_W = 4,
    localparam int RIGHTS_W = 2 * (1 << KEY_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                rsvd_hit,
    input  logic                page_user,
    input  logic                page_writable,
    input  logic                page_noexec,
    input  logic [KEY_W-1:0]    page_key,
    input  logic                priv_user,
    input  logic [1:0]          acc_type,
    input  logic                wp_en,
    input  logic                smep_en,
    input  logic                smap_act,
    input  logic                nxe_en,
    input  logic                ukey_en,
    input  logic                skey_en,
    input  logic [RIGHTS_W-1:0] ukey_rights,
    input  logic [RIGHTS_W-1:0] skey_rights,
    output logic                done,
    output logic                fault,
    output logic [PERM_W-1:0]   perm,
    output logic [ERR_W-1:0]    err_code
);
    logic [PERM_W-1:0] base;
    logic [PERM_W-1:0] kmask;
    logic              fault_d;
    logic [ERR_W-1:0]  err_d;
    logic [PERM_W-1:0] perm_d;

    pkc_base_rights u_base (
        .page_user     (page_user),
        .page_writable (page_writable),
        .page_noexec   (page_noexec),
        .priv_user     (priv_user),
        .wp_en         (wp_en),
        .smep_en       (smep_en),
        .smap_act      (smap_act),
        .base          (base)
    );

    pkc_key_rights #(.KEY_W(KEY_W)) u_key (
        .page_user   (page_user),
        .page_key    (page_key),
        .priv_user   (priv_user),
        .wp_en       (wp_en),
        .ukey_en     (ukey_en),
        .skey_en     (skey_en),
        .ukey_rights (ukey_rights),
        .skey_rights (skey_rights),
        .kmask       (kmask)
    );

    pkc_fault_code u_code (
        .rsvd_hit  (rsvd_hit),
        .page_user (page_user),
        .priv_user (priv_user),
        .acc_type  (acc_type),
        .nxe_en    (nxe_en),
        .smep_en   (smep_en),
        .base      (base),
        .kmask     (kmask),
        .fault     (fault_d),
        .err       (err_d),
        .perm      (perm_d)
    );

    // Done pulse one cycle after each request
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= req_valid;
    end

    // Capture the verdict on a request and hold it until the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault    <= 1'b0;
            perm     <= '0;
            err_code <= '0;
        end else if (req_valid) begin
            fault    <= fault_d;
            perm     <= perm_d;
            err_code <= err_d;
        end
    end
endmodule

// File: rtl/pkc_checker.sv
// Temporal checks on the checker's ports; attached by bind below.
module pkc_checker
    import pkc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              priv_user,
    input logic [1:0]        acc_type,
    input logic              done,
    input logic              fault,
    input logic [PERM_W-1:0] perm,
    input logic [ERR_W-1:0]  err_code
);
    // R1: each request yields done on the next cycle
    a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    // R1: no done without a request one cycle earlier
    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid));

    // R8: a fetch never reports a key fault
    a_r8_fetch_no_key: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(acc_type) == ACC_FETCH) |-> !err_code[EC_KEY]);

    // R8: a key fault always carries the present flag
    a_r8_key_has_present: assert property (@(posedge clk) disable iff (!rst_n)
        err_code[EC_KEY] |-> err_code[EC_PRESENT]);

    // R10: user flag follows the privilege of the request
    a_r10_user_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (err_code[EC_USER] == $past(priv_user)));

    // R10: write flag marks stores exactly
    a_r10_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (err_code[EC_WRITE] == ($past(acc_type) == ACC_STORE)));

    // R12: a fault grants nothing; a pass has an empty code
    a_r12_fault_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (perm == '0));
    a_r12_pass_no_code: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (err_code == '0));

    // R4: write is never granted without read
    a_r4_write_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        perm[PERM_WR] |-> perm[PERM_RD]);
endmodule

bind pkey_perm_check pkc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .priv_user (priv_user),
    .acc_type  (acc_type),
    .done      (done),
    .fault     (fault),
    .perm      (perm),
    .err_code  (err_code)
);

// File: tb/sim_pkey_perm_check.sv
// Directed bench: one task per scenario, each comparing to a rule model.
module sim_pkey_perm_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        rsvd_hit = 1'b0, page_user = 1'b0, page_writable = 1'b0, page_noexec = 1'b0;
    logic [3:0]  page_key = '0;
    logic        priv_user = 1'b0;
    logic [1:0]  acc_type = 2'd0;
    logic        wp_en = 1'b0, smep_en = 1'b0, smap_act = 1'b0, nxe_en = 1'b0;
    logic        ukey_en = 1'b0, skey_en = 1'b0;
    logic [31:0] ukey_rights = '0, skey_rights = '0;
    logic        done, fault;
    logic [2:0]  perm;
    logic [5:0]  err_code;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pkey_perm_check u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsvd_hit(rsvd_hit),
        .page_user(page_user), .page_writable(page_writable), .page_noexec(page_noexec),
        .page_key(page_key), .priv_user(priv_user), .acc_type(acc_type),
        .wp_en(wp_en), .smep_en(smep_en), .smap_act(smap_act), .nxe_en(nxe_en),
        .ukey_en(ukey_en), .skey_en(skey_en), .ukey_rights(ukey_rights),
        .skey_rights(skey_rights), .done(done), .fault(fault), .perm(perm),
        .err_code(err_code)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Rule model from the requirements: returns {fault, err[5:0], perm[2:0]}
    function automatic logic [9:0] model();
        logic r, w, x, ad, wd, kr, kw, ok;
        logic [31:0] rg;
        logic [5:0] side;
        r = !(smap_act && page_user);
        w = r && (page_writable || (!priv_user && !wp_en));
        x = !page_noexec && (priv_user || !smep_en || !page_user);
        rg = page_user ? (ukey_en ? ukey_rights : 32'h0) : (skey_en ? skey_rights : 32'h0);
        ad = rg[2*page_key];
        wd = rg[2*page_key+1];
        kr = !ad;
        kw = !ad && !(wd && (priv_user || wp_en));
        side = (priv_user ? 6'h04 : 6'h0) | (acc_type == 2'd1 ? 6'h02 : 6'h0) |
               ((acc_type == 2'd2 && (nxe_en || smep_en)) ? 6'h10 : 6'h0);
        if (rsvd_hit) return {1'b1, 6'h08 | side, 3'b0};
        if (priv_user && !page_user) return {1'b1, 6'h01 | side, 3'b0};
        if ((acc_type == 2'd1 && !kw) || (acc_type != 2'd1 && acc_type != 2'd2 && !kr))
            return {1'b1, 6'h21 | side, 3'b0};
        case (acc_type)
            2'd1: ok = w && kw;
            2'd2: ok = x;
            default: ok = r && kr;
        endcase
        if (!ok) return {1'b1, 6'h01 | side, 3'b0};
        return {1'b0, 6'h0, {x, w && kw, r && kr}};
    endfunction

    // Issue one request, check the result one cycle later and the done drop
    task automatic run(string req);
        logic [9:0] e;
        e = model();
        @(negedge clk); req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        chk({req, " done"}, done, 1);
        chk({req, " fault"}, fault, e[9]);
        chk({req, " err"}, err_code, e[8:3]);
        chk({req, " perm"}, perm, e[2:0]);
        @(negedge clk);
        chk("R1 done pulse", done, 0);
        chk("R1 hold", {fault, err_code, perm}, e);
    endtask

    task automatic clear_all();
        rsvd_hit = 0; page_user = 0; page_writable = 0; page_noexec = 0; page_key = 0;
        priv_user = 0; acc_type = 0; wp_en = 0; smep_en = 0; smap_act = 0; nxe_en = 0;
        ukey_en = 0; skey_en = 0; ukey_rights = 0; skey_rights = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset done", done, 0);
        chk("R1 reset out", {fault, err_code, perm}, 0);
    endtask

    task automatic t_base();
        clear_all(); page_user = 1; page_writable = 1; priv_user = 1; run("R3 R4 R5 user rw");
        page_writable = 0; run("R4 user ro load");
        acc_type = 1; run("R4 user ro store");
        clear_all(); page_writable = 0; acc_type = 1; run("R4 sup store wp off");
        wp_en = 1; run("R4 sup store wp on");
        clear_all(); page_user = 1; smap_act = 1; page_writable = 1; run("R3 smap load");
        acc_type = 2; run("R3 smap fetch");
        clear_all(); page_user = 1; smep_en = 1; acc_type = 2; run("R5 smep sup fetch");
        priv_user = 1; run("R5 smep user fetch");
        clear_all(); page_noexec = 1; nxe_en = 1; acc_type = 2; run("R5 noexec fetch");
        clear_all(); acc_type = 2; run("R10 fetch no I flag");
    endtask

    task automatic t_priv();
        clear_all(); priv_user = 1; page_writable = 1; acc_type = 1; run("R2 user on sup page");
        rsvd_hit = 1; run("R9 rsvd over R2");
        clear_all(); rsvd_hit = 1; acc_type = 2; smep_en = 1; run("R9 rsvd fetch");
    endtask

    task automatic t_keys();
        clear_all(); page_user = 1; page_writable = 1; priv_user = 1; page_key = 4'd5;
        ukey_rights = 32'h1 << 10; run("R6 user keys off");
        ukey_en = 1; run("R7 R8 access-disable load");
        acc_type = 2; run("R8 fetch ignores key");
        acc_type = 1; ukey_rights = 32'h1 << 11; run("R7 R8 write-disable store");
        acc_type = 0; run("R7 write-disable load ok");
        page_key = 4'd15; ukey_rights = 32'h8000_0000; acc_type = 1; run("R7 top key wd");
        clear_all(); page_writable = 1; acc_type = 1; page_key = 4'd0;
        skey_rights = 32'h2; skey_en = 1; run("R7 sup wd wp off");
        wp_en = 1; run("R7 sup wd wp on");
        ukey_en = 1; skey_en = 0; ukey_rights = 32'h3; run("R6 sup page ignores user reg");
        clear_all(); page_user = 1; priv_user = 1; page_key = 4'd3; ukey_en = 1;
        ukey_rights = 32'h40; smap_act = 1; run("R8 R11 key and smap overlap");
        clear_all(); page_user = 1; priv_user = 1; acc_type = 1; page_key = 4'd2; ukey_en = 1;
        ukey_rights = 32'h20; run("R8 R11 wd and read-only overlap");
        page_writable = 1; ukey_rights = 32'h10; skey_en = 1; skey_rights = 32'h0; run("R6 user ad store");
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_base();
        t_priv();
        t_keys();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule